// File: doc/BRIEF.md
# Clock Reference Selection Controller

This block decides which of eight clock reference inputs feeds a downstream timing loop, and in which operating mode that loop runs: free run, holdover, or locked to one reference. Each cycle it reads one qualification flag per reference. Configuration comes from a small register-style write port, which holds the control mode, a per-reference exclusion mask, a per-reference priority and an acquisition hold count.

There are two kinds of control. In autonomous control the block chooses the reference itself from priority and qualification, and the revertive setting decides whether it returns to a better reference. In manual control the software forces free run, forces holdover, or names one reference to lock to. If that reference is not usable, the block falls back to holdover.

Every change of operating mode, selected reference or qualification pattern sets a sticky cause bit. The active-low interrupt stays asserted until software clears all set cause bits with a write-one-to-clear acknowledge.

Top module: `refsel_ctrl`

## Requirements
- R1: After reset `op_mode` is free run (0), `sel_ref` is 0, `irq_cause` is 0 and `irq_n` is high. Mode codes are 0 free run, 1 holdover, 2 locked. The control register is at address 0 and its reset value selects autonomous, revertive.
- R2: In autonomous control a reference is eligible when it is qualified, unmasked and has a nonzero priority. The chosen reference is the eligible one with the numerically largest priority, and ties go to the lower index. Priority of reference i is written at address 2, bits [4i+3:4i], and resets to 0 (never selected).
- R3: From free run or holdover the block enters locked on the H-th consecutive clock edge at which the same target is usable. H is written at address 3, and H of 0 or 1 means the first such edge.
- R4: In autonomous control, when the locked reference stops being eligible, the block moves on the next edge to the best other eligible reference. If none is eligible it enters holdover and `sel_ref` keeps its last value.
- R5: Revertive (control bit 1 = 1): while locked, the block moves to an eligible reference only if that reference has a strictly larger priority than the current one. An equal priority causes no move.
- R6: Non-revertive (control bit 1 = 0): while the current reference stays eligible, the block does not leave it, even when a higher-priority reference becomes eligible.
- R7: Manual control (control bit 0 = 0) with forced mode field bits [3:2] = 0 gives free run. Field value 1 gives holdover.
- R8: Manual control with forced mode 2 locks to the reference in bits [6:4] once it is qualified and unmasked; its priority is ignored and entry follows the R3 count. If that reference is lost the block enters holdover, and it relocks after the reference returns.
- R9: A mask bit set to 1 at address 1 excludes that reference from selection, in both control modes, even while it is qualified.
- R10: Cause bits are bit 0 mode change, bit 1 selected reference change and bit 2 qualification flags change. Each is set at the edge of its event. `irq_n` is low while any cause bit is set. Writing ones to address 4 clears those bits, and a new event in the same cycle wins over the clear.
- R11: Once low, `irq_n` stays low until an acknowledge write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_qual | input | 8 | Per-reference qualification flags |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| sel_ref | output | 3 | Selected reference index |
| op_mode | output | 2 | Operating mode: 0 free run, 1 holdover, 2 locked |
| irq_n | output | 1 | Active-low interrupt |
| irq_cause | output | 3 | Sticky cause snapshot |

## Verification
The properties assume that `ref_qual` and the configuration inputs are synchronous to `clk` and stable around each rising edge. They also assume that the manual reference index names one of the eight references. The bench changes every input only on the falling edge, so each change reaches the design on the next rising edge. It writes only defined addresses, and it keeps the forced index in range, so the invariant that a locked state follows a qualified reference holds for every stimulus it applies.

// File: rtl/refsel_ctrl.sv
module refsel_ctrl #(
  parameter int NREF     = 8,
  parameter int PRIO_W   = 4,
  parameter int QCNT_W   = 8,
  parameter int DEF_HOLD = 4,
  localparam int SW = $clog2(NREF),
  localparam int DW = NREF * PRIO_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NREF-1:0] ref_qual,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [SW-1:0] sel_ref,
  output logic [1:0]    op_mode,
  output logic          irq_n,
  output logic [2:0]    irq_cause
);

  localparam logic [1:0] M_FREE = 2'd0;
  localparam logic [1:0] M_HOLD = 2'd1;
  localparam logic [1:0] M_LOCK = 2'd2;
  localparam logic [QCNT_W:0] RUN_MAX = {1'b0, {QCNT_W{1'b1}}};

  logic              auto_q, rev_q;
  logic [1:0]        man_mode_q;
  logic [SW-1:0]     man_ref_q;
  logic [NREF-1:0]   mask_q;
  logic [PRIO_W-1:0] prio_q [NREF];
  logic [QCNT_W-1:0] hold_q;

  logic [1:0]        mode_q, mode_d;
  logic [SW-1:0]     cur_q, cur_d, cand_q, best, tgt;
  logic [QCNT_W-1:0] run_q;
  logic [QCNT_W:0]   run_now;
  logic [NREF-1:0]   qual_q, elig;
  logic [PRIO_W-1:0] best_p;
  logic              any_elig, man_ok, tgt_ok;
  logic [2:0]        cause_q, ev, ack_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_q     <= 1'b1;
      rev_q      <= 1'b1;
      man_mode_q <= M_FREE;
      man_ref_q  <= '0;
      mask_q     <= '0;
      hold_q     <= QCNT_W'(DEF_HOLD);
      for (int i = 0; i < NREF; i++) prio_q[i] <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0: begin
          auto_q     <= cfg_wdata[0];
          rev_q      <= cfg_wdata[1];
          man_mode_q <= cfg_wdata[3:2];
          man_ref_q  <= cfg_wdata[4 +: SW];
        end
        3'd1: mask_q <= cfg_wdata[NREF-1:0];
        3'd2: for (int i = 0; i < NREF; i++) prio_q[i] <= cfg_wdata[i*PRIO_W +: PRIO_W];
        3'd3: hold_q <= cfg_wdata[QCNT_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NREF; g++) begin : g_elig
    assign elig[g] = ref_qual[g] & ~mask_q[g] & (prio_q[g] != '0);
  end

  always_comb begin
    best   = '0;
    best_p = '0;
    for (int i = 0; i < NREF; i++) begin
      if (elig[i] && prio_q[i] > best_p) begin
        best   = SW'(i);
        best_p = prio_q[i];
      end
    end
  end

  assign any_elig = best_p != '0;
  assign man_ok   = ref_qual[man_ref_q] & ~mask_q[man_ref_q];
  assign tgt      = auto_q ? best : man_ref_q;
  assign tgt_ok   = auto_q ? any_elig : (man_mode_q == M_LOCK) && man_ok;
  assign run_now  = (tgt == cand_q && run_q != '0) ? {1'b0, run_q} + 1'b1 : (QCNT_W+1)'(1);

  always_comb begin
    mode_d = mode_q;
    cur_d  = cur_q;
    if (!auto_q && man_mode_q != M_LOCK) begin
      mode_d = (man_mode_q == M_FREE) ? M_FREE : M_HOLD;
    end else if (mode_q == M_LOCK) begin
      if (!auto_q) begin
        if (!man_ok) mode_d = M_HOLD;
        else         cur_d  = man_ref_q;
      end else if (!elig[cur_q]) begin
        if (any_elig) cur_d  = best;
        else          mode_d = M_HOLD;
      end else if (rev_q && best_p > prio_q[cur_q]) begin
        cur_d = best;
      end
    end else if (tgt_ok && run_now >= {1'b0, hold_q}) begin
      mode_d = M_LOCK;
      cur_d  = tgt;
    end
  end

  assign ev       = {qual_q != ref_qual, cur_d != cur_q, mode_d != mode_q};
  assign ack_bits = (cfg_we && cfg_addr == 3'd4) ? cfg_wdata[2:0] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_FREE;
      cur_q   <= '0;
      cand_q  <= '0;
      run_q   <= '0;
      qual_q  <= '0;
      cause_q <= '0;
    end else begin
      mode_q  <= mode_d;
      cur_q   <= cur_d;
      qual_q  <= ref_qual;
      cause_q <= (cause_q & ~ack_bits) | ev;
      if (mode_d == M_LOCK || !tgt_ok) begin
        run_q <= '0;
      end else begin
        cand_q <= tgt;
        run_q  <= (run_now > RUN_MAX) ? RUN_MAX[QCNT_W-1:0] : run_now[QCNT_W-1:0];
      end
    end
  end

  assign sel_ref   = cur_q;
  assign op_mode   = mode_q;
  assign irq_cause = cause_q;
  assign irq_n     = ~|cause_q;

endmodule

// File: rtl/refsel_ctrl_chk.sv
module refsel_ctrl_chk #(
  parameter int NREF = 8,
  localparam int SW = $clog2(NREF)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREF-1:0] ref_qual,
  input logic            cfg_we,
  input logic [2:0]      cfg_addr,
  input logic [SW-1:0]   sel_ref,
  input logic [1:0]      op_mode,
  input logic            irq_n
);

  p_lock_qualified_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode == 2'd2) |-> ((($past(ref_qual) >> sel_ref) & NREF'(1)) != '0));

  p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    op_mode != 2'd3);

  p_mode_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode != $past(op_mode)) |-> !irq_n);

  p_ref_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ref != $past(sel_ref)) |-> !irq_n);

  p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !(cfg_we && cfg_addr == 3'd4)) |=> !irq_n);

endmodule

bind refsel_ctrl refsel_ctrl_chk #(.NREF(NREF)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_qual(ref_qual), .cfg_we(cfg_we),
  .cfg_addr(cfg_addr), .sel_ref(sel_ref), .op_mode(op_mode), .irq_n(irq_n)
);

// File: tb/refsel_ctrl_tb.sv
module refsel_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ref_qual = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  sel_ref;
  logic [1:0]  op_mode;
  logic        irq_n;
  logic [2:0]  irq_cause;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  refsel_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ref_qual(ref_qual), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .sel_ref(sel_ref),
    .op_mode(op_mode), .irq_n(irq_n), .irq_cause(irq_cause)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 mode", op_mode, 0);
    chk("R1 sel", sel_ref, 0);
    chk("R1 irq_n", irq_n, 1);
    chk("R1 cause", irq_cause, 0);
  endtask

  task automatic t_acquire;
    wr(3'd2, 32'h0000_0500);
    wr(3'd3, 32'd4);
    ref_qual = 8'h04;
    step(3);
    chk("R3 not yet locked", op_mode, 0);
    step(1);
    chk("R3 locked on 4th edge", op_mode, 2);
    chk("R2 sel", sel_ref, 2);
    chk("R10 cause all", irq_cause, 7);
    step(5);
    chk("R11 irq held", irq_n, 0);
    wr(3'd4, 32'd7);
    chk("R10 ack cause", irq_cause, 0);
    chk("R10 ack irq_n", irq_n, 1);
    wr(3'd3, 32'd1);
  endtask

  task automatic t_revert;
    wr(3'd2, 32'h0000_9590);
    ref_qual = 8'h0C; step(2);
    chk("R5 revert to higher", sel_ref, 3);
    ref_qual = 8'h0E; step(3);
    chk("R5 equal priority stays", sel_ref, 3);
    ref_qual = 8'h06; step(2);
    chk("R4 loss switch sel", sel_ref, 1);
    chk("R4 loss switch mode", op_mode, 2);
    ref_qual = 8'h00; step(2);
    chk("R4 holdover", op_mode, 1);
    chk("R4 sel kept", sel_ref, 1);
    ref_qual = 8'h0A; step(2);
    chk("R2 tie lower index", sel_ref, 1);
    chk("R2 relocked", op_mode, 2);
  endtask

  task automatic t_mask;
    wr(3'd1, 32'h02); step(1);
    chk("R9 masked current left", sel_ref, 3);
    wr(3'd1, 32'h0A); step(1);
    chk("R9 all masked holdover", op_mode, 1);
    wr(3'd1, 32'h00); step(1);
    chk("R9 unmask relock", sel_ref, 1);
    chk("R9 unmask mode", op_mode, 2);
  endtask

  task automatic t_nonrev;
    wr(3'd0, 32'h1);
    ref_qual = 8'h04; step(2);
    chk("R6 move on loss", sel_ref, 2);
    ref_qual = 8'h06; step(4);
    chk("R6 stays on current", sel_ref, 2);
    chk("R6 mode", op_mode, 2);
    ref_qual = 8'h02; step(2);
    chk("R6 switch after loss", sel_ref, 1);
  endtask

  task automatic t_manual;
    wr(3'd0, 32'h0); step(1);
    chk("R7 forced free run", op_mode, 0);
    wr(3'd4, 32'd7);
    wr(3'd0, 32'h4); step(1);
    chk("R7 forced holdover", op_mode, 1);
    chk("R10 mode cause only", irq_cause, 1);
    chk("R10 irq low", irq_n, 0);
    ref_qual = 8'h12;
    wr(3'd0, 32'h48); step(2);
    chk("R8 lock named ref", sel_ref, 4);
    chk("R8 locked", op_mode, 2);
    ref_qual = 8'h02; step(2);
    chk("R8 loss holdover", op_mode, 1);
    wr(3'd1, 32'h10);
    ref_qual = 8'h12; step(3);
    chk("R9 manual masked", op_mode, 1);
    wr(3'd1, 32'h00); step(2);
    chk("R8 relock", op_mode, 2);
    chk("R8 relock sel", sel_ref, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_acquire();
    t_revert();
    t_mask();
    t_nonrev();
    t_manual();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule